// File: doc/BRIEF.md
# Cascaded Time-of-Day Digit Counter

This block keeps the time of day as six BCD digits: hours, minutes and seconds, each as a tens and a units digit. A one-cycle enable that pulses once per second drives the chain. Each digit is a small modulo counter. A units digit counts 0 to 9 and a tens digit of seconds or minutes counts 0 to 5. A digit moves only in a cycle where every digit below it is at its last value and the tick is high. Because each carry is decoded combinationally from the present digits, one clock edge updates the whole time, even for a full-day rollover.

The hours pair is handled as one two-digit stage. A plain select input picks 24-hour operation, which runs 00 to 23, or 12-hour operation, which runs 01 to 12. A synchronous reset loads midnight in the format that the select shows at the reset edge. The block has no data stream, so every pin is plain control or status, with no handshake.

Top module: `tod_clock_chain`

## Requirements
- R1: The seconds units digit counts 0 to 9 in BCD, one step per cycle with `sec_tick` high, and wraps from 9 to 0.
- R2: The seconds tens digit counts 0 to 5 and steps only when the units digit wraps, so seconds go from 59 to 00.
- R3: The minutes digits count 00 to 59 the same way. They advance only on the edge where the seconds go from 59 to 00.
- R4: The hours advance only on the edge where minutes and seconds go from 59:59 to 00:00. An hours units value of 9 steps to 0 and the tens digit rises by one.
- R5: With `mode12` = 0, the hours run 00 to 23, and 23:59:59 goes to 00:00:00.
- R6: With `mode12` = 1, the hours run 01 to 12, with 09 going to 10 and 12:59:59 going to 01:00:00.
- R7: When `rst` is high at an edge, all digits load 00:00:00 if `mode12` = 0, or 12:00:00 if `mode12` = 1. Reset takes priority over `sec_tick`.
- R8: In a cycle with `sec_tick` low, every digit holds its value. Ticks separated by idle cycles each advance the time by exactly one second.
- R9: A tick changes every affected digit on the same edge. 23:59:59 becomes 00:00:00 one edge after the tick, with no intermediate value.
- R10: A change of `mode12` alone does not change any digit. When the hours advance in 12-hour mode from a value outside 01 to 12, such as 00, they go to 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stages |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle enable, once per second |
| mode12 | input | 1 | 1 selects 12-hour hours, 0 selects 24-hour hours |
| hr_tens | output | DIGIT_W | Hours tens digit, BCD |
| hr_units | output | DIGIT_W | Hours units digit, BCD |
| min_tens | output | DIGIT_W | Minutes tens digit, BCD |
| min_units | output | DIGIT_W | Minutes units digit, BCD |
| sec_tens | output | DIGIT_W | Seconds tens digit, BCD |
| sec_units | output | DIGIT_W | Seconds units digit, BCD |

## Verification
The bench builds the block with its default digit width of 4. At that width every BCD value fits, so the whole 86,400-second day is reachable with ticks held high on consecutive cycles. This lets the bench stop at each decade boundary, at the 09-to-10 and 23-to-00 hour edges, and at the 12-to-01 edge in 12-hour mode. A short run from hour 00 in 12-hour mode reaches the path that corrects an out-of-range hour.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int UNITS_MOD = 10;
  localparam int TENS_MOD  = 6;

  // Modulus of a seconds/minutes stage: even index is a units digit.
  function automatic int stage_mod(input int idx);
    return (idx % 2 == 0) ? UNITS_MOD : TENS_MOD;
  endfunction
endpackage

// File: rtl/tod_mod_digit.sv
module tod_mod_digit #(
  parameter int W       = 4,
  parameter int MODULUS = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] digit,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  logic at_last;
  assign at_last = (digit == LAST);
  assign wrap    = en & at_last;

  always_ff @(posedge clk) begin
    if (rst)          digit <= '0;
    else if (en) begin
      if (at_last)    digit <= '0;
      else            digit <= digit + 1'b1;
    end
  end
endmodule

// File: rtl/tod_hour_stage.sv
module tod_hour_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         mode12,
  output logic [W-1:0] tens,
  output logic [W-1:0] units
);
  localparam logic [W-1:0] D0 = W'(0);
  localparam logic [W-1:0] D1 = W'(1);
  localparam logic [W-1:0] D2 = W'(2);
  localparam logic [W-1:0] D3 = W'(3);
  localparam logic [W-1:0] D9 = W'(9);

  logic top24, top12, at_top;
  logic [W-1:0] nxt_tens, nxt_units;

  // Last hour of each format, or beyond it.
  assign top24  = (tens > D2) || (tens == D2 && units >= D3);
  assign top12  = (tens > D1) || (tens == D1 && units >= D2);
  assign at_top = mode12 ? top12 : top24;

  always_comb begin
    if (at_top) begin
      nxt_tens  = D0;
      nxt_units = mode12 ? D1 : D0;
    end else if (units >= D9) begin
      nxt_tens  = tens + 1'b1;
      nxt_units = D0;
    end else begin
      nxt_tens  = tens;
      nxt_units = units + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tens  <= mode12 ? D1 : D0;
      units <= mode12 ? D2 : D0;
    end else if (en) begin
      tens  <= nxt_tens;
      units <= nxt_units;
    end
  end
endmodule

// File: rtl/tod_clock_chain.sv
module tod_clock_chain
  import tod_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_tick,
  input  logic               mode12,
  output logic [DIGIT_W-1:0] hr_tens,
  output logic [DIGIT_W-1:0] hr_units,
  output logic [DIGIT_W-1:0] min_tens,
  output logic [DIGIT_W-1:0] min_units,
  output logic [DIGIT_W-1:0] sec_tens,
  output logic [DIGIT_W-1:0] sec_units
);
  localparam int NSTAGE = 4;  // seconds units/tens, minutes units/tens

  logic [NSTAGE:0]      carry;
  logic [DIGIT_W-1:0]   digs [NSTAGE];

  assign carry[0] = sec_tick;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    tod_mod_digit #(
      .W       (DIGIT_W),
      .MODULUS (stage_mod(i))
    ) u_digit (
      .clk   (clk),
      .rst   (rst),
      .en    (carry[i]),
      .digit (digs[i]),
      .wrap  (carry[i+1])
    );
  end

  tod_hour_stage #(
    .W (DIGIT_W)
  ) u_hours (
    .clk    (clk),
    .rst    (rst),
    .en     (carry[NSTAGE]),
    .mode12 (mode12),
    .tens   (hr_tens),
    .units  (hr_units)
  );

  assign sec_units = digs[0];
  assign sec_tens  = digs[1];
  assign min_units = digs[2];
  assign min_tens  = digs[3];
endmodule

// File: rtl/tod_clock_chain_chk.sv
module tod_clock_chain_chk #(
  parameter int DIGIT_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               sec_tick,
  input logic               mode12,
  input logic [DIGIT_W-1:0] hr_tens,
  input logic [DIGIT_W-1:0] hr_units,
  input logic [DIGIT_W-1:0] min_tens,
  input logic [DIGIT_W-1:0] min_units,
  input logic [DIGIT_W-1:0] sec_tens,
  input logic [DIGIT_W-1:0] sec_units
);
  logic s59, m59;
  assign s59 = (sec_tens == DIGIT_W'(5)) && (sec_units == DIGIT_W'(9));
  assign m59 = (min_tens == DIGIT_W'(5)) && (min_units == DIGIT_W'(9));

  a_r1_units_range: assert property (@(posedge clk) disable iff (rst)
    sec_units <= DIGIT_W'(9) && min_units <= DIGIT_W'(9));

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    sec_tick && s59 |=> sec_tens == '0 && sec_units == '0);

  a_r3_min_hold: assert property (@(posedge clk) disable iff (rst)
    !(sec_tick && s59) |=> $stable(min_tens) && $stable(min_units));

  a_r4_hr_hold: assert property (@(posedge clk) disable iff (rst)
    !(sec_tick && s59 && m59) |=> $stable(hr_tens) && $stable(hr_units));

  a_r5_day_wrap: assert property (@(posedge clk) disable iff (rst)
    sec_tick && !mode12 && s59 && m59 && hr_tens == DIGIT_W'(2) && hr_units == DIGIT_W'(3)
    |=> hr_tens == '0 && hr_units == '0 && min_tens == '0 && sec_tens == '0);

  a_r6_half_wrap: assert property (@(posedge clk) disable iff (rst)
    sec_tick && mode12 && s59 && m59 && hr_tens == DIGIT_W'(1) && hr_units == DIGIT_W'(2)
    |=> hr_tens == '0 && hr_units == DIGIT_W'(1));

  a_r7_reset_value: assert property (@(posedge clk)
    rst |=> hr_tens == ($past(mode12) ? DIGIT_W'(1) : DIGIT_W'(0)) &&
            hr_units == ($past(mode12) ? DIGIT_W'(2) : DIGIT_W'(0)) &&
            min_tens == '0 && min_units == '0 && sec_tens == '0 && sec_units == '0);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> $stable(sec_units) && $stable(sec_tens) && $stable(hr_units));
endmodule

bind tod_clock_chain tod_clock_chain_chk #(.DIGIT_W(DIGIT_W)) u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .mode12(mode12),
  .hr_tens(hr_tens), .hr_units(hr_units), .min_tens(min_tens),
  .min_units(min_units), .sec_tens(sec_tens), .sec_units(sec_units)
);

// File: tb/tod_clock_chain_tb.sv
`timescale 1ns/1ps
module tod_clock_chain_tb;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0;
  logic mode12 = 1'b0;
  logic [W-1:0] hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  tod_clock_chain #(.DIGIT_W(W)) u_dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .mode12(mode12),
    .hr_tens(hr_tens), .hr_units(hr_units), .min_tens(min_tens),
    .min_units(min_units), .sec_tens(sec_tens), .sec_units(sec_units)
  );

  function automatic logic [23:0] bcd_time(input int h, input int m, input int s);
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  task automatic check_time(input string req, input int h, input int m, input int s);
    logic [23:0] got, exp;
    got = {hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units};
    exp = bcd_time(h, m, s);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // Tick high for n consecutive cycles; returns at a falling edge.
  task automatic run_ticks(input int n);
    @(negedge clk) sec_tick = 1'b1;
    repeat (n) @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic do_reset(input logic m12);
    @(negedge clk) begin rst = 1'b1; mode12 = m12; end
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    check_time("R7 reset 24h", 0, 0, 0);
    @(negedge clk) begin rst = 1'b1; mode12 = 1'b1; sec_tick = 1'b1; end
    @(negedge clk) begin rst = 1'b0; sec_tick = 1'b0; end
    check_time("R7 reset 12h with tick", 12, 0, 0);
  endtask

  task automatic t_hold_and_gaps();
    do_reset(1'b0);
    repeat (4) @(negedge clk);
    check_time("R8 idle hold", 0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
    check_time("R8 gapped ticks", 0, 0, 5);
  endtask

  task automatic t_day_24();
    do_reset(1'b0);
    run_ticks(9);     check_time("R1 units to 9", 0, 0, 9);
    run_ticks(1);     check_time("R1 units wrap", 0, 0, 10);
    run_ticks(49);    check_time("R2 at 59", 0, 0, 59);
    run_ticks(1);     check_time("R2 R3 seconds wrap", 0, 1, 0);
    run_ticks(3539);  check_time("R3 minutes at 59", 0, 59, 59);
    run_ticks(1);     check_time("R4 hour advance", 1, 0, 0);
    run_ticks(32399); check_time("R4 hour 09", 9, 59, 59);
    run_ticks(1);     check_time("R4 hour BCD carry", 10, 0, 0);
    run_ticks(50399); check_time("R5 at 23:59:59", 23, 59, 59);
    run_ticks(1);     check_time("R5 R9 day wrap", 0, 0, 0);
  endtask

  task automatic t_half_12();
    do_reset(1'b1);
    run_ticks(3599);  check_time("R6 12:59:59", 12, 59, 59);
    run_ticks(1);     check_time("R6 12 to 01", 1, 0, 0);
    run_ticks(32399); check_time("R6 09:59:59", 9, 59, 59);
    run_ticks(1);     check_time("R6 09 to 10", 10, 0, 0);
    run_ticks(7199);  check_time("R6 11:59:59", 11, 59, 59);
    run_ticks(1);     check_time("R6 11 to 12", 12, 0, 0);
  endtask

  task automatic t_mode_switch();
    do_reset(1'b0);
    run_ticks(3599);
    @(negedge clk) mode12 = 1'b1;
    repeat (3) @(negedge clk);
    check_time("R10 select change holds", 0, 59, 59);
    run_ticks(1);     check_time("R10 hour 00 to 01 in 12h", 1, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_hold_and_gaps();
    t_day_24();
    t_half_12();
    t_mode_switch();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule